// File: doc/BRIEF.md
# PCI Interrupt Line Gate and Map Registers

This block sits between the level-sensitive interrupt requests of a PCI bus and the interrupt controller that receives them. It passes 32 request lines through to 32 outgoing lines. The lines are split into groups of four, and each group is controlled by one of eight 32-bit map registers. The top bit of a map register is its enable. While a register is enabled, the four lines it owns pass their input levels through. While it is disabled, those outputs are held low.

A simple register port gives software access to the map registers. Only the enable bit of each register can be written. The lower 31 bits are a fixed identification pattern that software reads back. The registers sit in a small address window, one every 8 bytes.

The block also provides a combinational helper. From the device/function number of a device behind a secondary bus and that device's interrupt pin, it computes which of the 32 input lines the device drives.

Top module: `irq_route_top`

## Requirements
- R1: Bits 30..0 of map register i always read as 0x7C0 | (i << 2), which is 0x1F shifted left by 6 with i in bits 4..2. Writes never change these bits.
- R2: A write takes effect only when all four byte enables are set and regAddr lies in 0xC00..0xC3F. The register index is regAddr[5:3], and regAddr[2:0] is ignored. The write loads bit 31 of that register from regWrData[31].
- R3: While rst_n is low, every enable bit is cleared and regRdData is zero. The identification bits stay as R1 gives them.
- R4: Output line n equals input line n when register n >> 2 is enabled. Otherwise output line n is 0.
- R5: A change to an enable bit shows on irqOut right after the clock edge that takes the write, with no change on irqIn.
- R6: A write with any byte enable clear leaves every map register unchanged.
- R7: A write outside 0xC00..0xC3F changes nothing. A read outside that window returns 0.
- R8: A read sampled on a clock edge places the register value on regRdData after that edge. The value stays there until the next read. A write in the same cycle as a read does not affect that read, which returns the value from before the write.
- R9: slotIndex = ((slotDevFn & 0x18) >> 1) + slotPin. This equals {slotDevFn[4:3], slotPin} and is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 16 | Register byte address |
| regWrEn | input | 1 | Write request |
| regRdEn | input | 1 | Read request |
| regByteEn | input | 4 | Byte enables of a write |
| regWrData | input | 32 | Write data; only bit 31 is used |
| regRdData | output | 32 | Registered read data |
| irqIn | input | 32 | Level interrupt requests from the bus |
| irqOut | output | 32 | Gated interrupt lines to the controller |
| slotDevFn | input | 8 | Device/function number of a secondary-bus device |
| slotPin | input | 2 | Interrupt pin of that device, 0 to 3 |
| slotIndex | output | 5 | Input line driven by that device and pin |

## Verification
irqOut and slotIndex are combinational from their inputs, so the bench checks them one time step after it drives new values, in the same low clock phase. A register write is taken on a rising edge. Its effect on irqOut, which depends on R5, is checked at the following falling edge. A read is sampled on a rising edge, and regRdData is compared at the falling edge after it. All stimulus changes on falling edges, so no check lands on the edge that moves the state.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int NUM_REGS      = 8;
  parameter int LINES_PER_REG = 4;
  parameter int DATA_W        = 32;
  parameter int ADDR_W        = 16;
  parameter int STRIDE_LOG2   = 3;
  parameter int WIN_BASE      = 'hC00;
  parameter int ID_BASE       = 'h1F << 6;

  localparam int NUM_LINES  = NUM_REGS * LINES_PER_REG;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int LINE_IDX_W = $clog2(NUM_LINES);
  localparam int BE_W       = DATA_W / 8;
  localparam int WIN_LOW_W  = IDX_W + STRIDE_LOG2;
  localparam int FIELD_W    = DATA_W - 1;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             enVal;
  } accStrobe_t;

  function automatic logic [FIELD_W-1:0] idField(input logic [IDX_W-1:0] i);
    return FIELD_W'(ID_BASE) | (FIELD_W'(i) << 2);
  endfunction
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [BE_W-1:0]   regByteEn,
  input  logic              wrTopBit,
  output accStrobe_t        strb
);
  localparam logic [ADDR_W-WIN_LOW_W-1:0] WIN_TAG = (ADDR_W-WIN_LOW_W)'(WIN_BASE >> WIN_LOW_W);

  logic inWindow;
  logic fullWord;

  always_comb begin
    inWindow   = (regAddr[ADDR_W-1:WIN_LOW_W] == WIN_TAG);
    fullWord   = &regByteEn;
    strb.hit   = inWindow;
    strb.idx   = regAddr[WIN_LOW_W-1:STRIDE_LOG2];
    strb.enVal = wrTopBit;
    strb.wr    = regWrEn && fullWord && inWindow;
    strb.rd    = regRdEn;
  end

  // R6: a partial write never reaches the register file
  a_r6_partial_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !(&regByteEn)) |-> !strb.wr);

  // R7: a write outside the window never reaches the register file
  a_r7_window_write: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && (regAddr < ADDR_W'(WIN_BASE))) |-> !strb.wr);
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  accStrobe_t            strb,
  output logic [DATA_W-1:0]     rdData,
  input  logic [NUM_LINES-1:0]  irqIn,
  output logic [NUM_LINES-1:0]  irqOut,
  input  logic [7:0]            slotDevFn,
  input  logic [1:0]            slotPin,
  output logic [LINE_IDX_W-1:0] slotIndex
);
  logic [NUM_REGS-1:0] enQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ <= '0;
    end else if (strb.wr) begin
      enQ[strb.idx] <= strb.enVal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (strb.rd) begin
      rdData <= strb.hit ? {enQ[strb.idx], idField(strb.idx)} : '0;
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_gate
    assign irqOut[n] = irqIn[n] & enQ[n / LINES_PER_REG];
  end

  assign slotIndex = LINE_IDX_W'({slotDevFn[4:3], slotPin});

  // R2: an accepted write lands in the addressed enable bit
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wr |=> (enQ[$past(strb.idx)] == $past(strb.enVal)));

  // R6: with no accepted write the enables hold
  a_r6_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wr |=> $stable(enQ));

  // R7: a read outside the window returns zero
  a_r7_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rd && !strb.hit) |=> (rdData == '0));

  // R1: the identification field reads back its fixed pattern
  a_r1_field_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rd && strb.hit) |=> (rdData[FIELD_W-1:0] == idField($past(strb.idx))));

  // R8: read data holds between reads
  a_r8_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rd |=> $stable(rdData));
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [BE_W-1:0]       regByteEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_LINES-1:0]  irqIn,
  output logic [NUM_LINES-1:0]  irqOut,
  input  logic [7:0]            slotDevFn,
  input  logic [1:0]            slotPin,
  output logic [LINE_IDX_W-1:0] slotIndex
);
  accStrobe_t strb;

  irq_route_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regByteEn (regByteEn),
    .wrTopBit  (regWrData[DATA_W-1]),
    .strb      (strb)
  );

  irq_route_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .rdData    (regRdData),
    .irqIn     (irqIn),
    .irqOut    (irqOut),
    .slotDevFn (slotDevFn),
    .slotPin   (slotPin),
    .slotIndex (slotIndex)
  );
endmodule

// File: tb/irq_route_top_test.sv
module irq_route_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] irqIn = '0;
  logic [31:0] irqOut;
  logic [7:0]  slotDevFn = '0;
  logic [1:0]  slotPin = '0;
  logic [4:0]  slotIndex;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 0;
  logic [7:0] expEn = '0;

  always #2.5 clk = ~clk;

  irq_route_top uut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regByteEn(regByteEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqIn(irqIn), .irqOut(irqOut),
    .slotDevFn(slotDevFn), .slotPin(slotPin), .slotIndex(slotIndex)
  );

  function automatic logic [31:0] lineMask(input logic [7:0] en);
    logic [31:0] m;
    for (int n = 0; n < 32; n++) m[n] = en[n >> 2];
    return m;
  endfunction

  function automatic logic [31:0] regValue(input logic [2:0] i, input logic en);
    return {en, 31'h7C0 | (31'(i) << 2)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkGate(input string req);
    check(req, irqOut, irqIn & lineMask(expEn));
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regByteEn = be; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (be == 4'hF && a >= 16'hC00 && a <= 16'hC3F) expEn[a[5:3]] = d[31];
    checkGate("R5");
  endtask

  task automatic doRead(input logic [15:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    exp = (a >= 16'hC00 && a <= 16'hC3F) ? regValue(a[5:3], expEn[a[5:3]]) : 32'h0;
    @(negedge clk);
    regRdEn = 1'b0;
    check(req, regRdData, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errCount++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    irqIn = 32'hFFFF_FFFF;
    #1;
    check("R3", irqOut, 32'h0);
    check("R3", regRdData, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) doRead(16'hC00 + 16'(i * 8), "R1");

    doWrite(16'hC10, 4'hF, 32'h8000_0000);
    checkGate("R4");
    doRead(16'hC10, "R2");
    doWrite(16'hC17, 4'hF, 32'hFFFF_FFFF);
    doRead(16'hC10, "R1");
    doWrite(16'hC18, 4'h7, 32'h8000_0000);
    doRead(16'hC18, "R6");
    doWrite(16'hC40, 4'hF, 32'h8000_0000);
    doWrite(16'h0BF8, 4'hF, 32'h8000_0000);
    check("R7", {24'h0, expEn}, {24'h0, 8'h04});
    checkGate("R7");
    doRead(16'hC40, "R7");
    doRead(16'h0C00 - 16'h8, "R7");

    @(negedge clk);
    regAddr = 16'hC08; regRdEn = 1'b1; regWrEn = 1'b1; regByteEn = 4'hF;
    regWrData = 32'h8000_0000;
    @(negedge clk);
    regRdEn = 1'b0; regWrEn = 1'b0;
    check("R8", regRdData, regValue(3'd1, 1'b0));
    expEn[1] = 1'b1;
    checkGate("R5");
    repeat (2) @(negedge clk);
    check("R8", regRdData, regValue(3'd1, 1'b0));

    for (int d = 0; d < 32; d++) begin
      slotDevFn = 8'($urandom);
      slotPin = 2'($urandom);
      #1;
      check("R9", 32'(slotIndex), 32'(((slotDevFn & 8'h18) >> 1) + 8'(slotPin)));
    end

    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 3);
      logic [15:0] a;
      if ($urandom_range(0, 4) == 0) a = 16'($urandom);
      else a = 16'hC00 + 16'($urandom_range(0, 63));
      case (op)
        0: doWrite(a, ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF, $urandom);
        1: doRead(a, "R2");
        default: begin
          @(negedge clk);
          irqIn = $urandom;
          #1;
          checkGate("R4");
        end
      endcase
    end

    doWrite(16'hC38, 4'hF, 32'h8000_0000);
    @(negedge clk);
    rst_n = 1'b0;
    irqIn = 32'hFFFF_FFFF;
    expEn = '0;
    #1;
    check("R3", irqOut, 32'h0);
    check("R3", regRdData, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) doRead(16'hC00 + 16'(i * 8), "R3");
    summary();
  end
endmodule